// File: doc/BRIEF.md
# I2S Master Serial Audio Port

This block is a master-only stereo serial audio port. It runs directly from a master clock at 256 times the sample rate. It divides that clock by four to make a bit clock with 64 bit periods per stereo frame, that is 32 bit slots per channel. It also drives a word-select line that marks the left and the right half of each frame. Samples of 8, 16, 18, 20 or 24 bits are placed inside each 32-bit channel slot in one of three framings: I2S (one bit delayed), left-justified or right-justified. Bit-clock polarity and word-select polarity can each be inverted.

Samples reach the block as left/right pairs on a valid/ready stream that fills a small transmit FIFO. One pair is taken from the FIFO at every frame boundary and sent during the next frame. Received pairs, captured either from the data pin or through an internal loopback, go into a receive FIFO that is drained by a second valid/ready stream.

The transmit stream accepts a pair only when `tx_valid` and `tx_ready` are both high on a clock edge. `tx_ready` is low while the transmit FIFO is full or transmission is switched off. The receive stream holds `rx_valid`, `rx_left` and `rx_right` unchanged until `rx_ready` is seen high. If the consumer applies back-pressure for long enough that the receive FIFO is full at a frame boundary, the frame is dropped and a sticky overflow flag is raised. The data pin can be turned into an input. A plain clock-enable and a disable input start the port, freeze it and clear it.

Top module: `i2s_master_port`

## Requirements
- R1: While reset is held, and until the first transmit pair arrives, the port reports an empty transmit FIFO, no receive data, both sticky error flags low, and a bit clock at its idle level (low when not inverted).
- R2: While running, the bit clock is low for master-clock cycles 0,1 and high for cycles 2,3 of every group of four, counting from the frame start. Setting `cfg_inv_bclk` inverts it, and its idle level when not running equals `cfg_inv_bclk`.
- R3: Word select is 0 for the first 128 master-clock cycles of a frame (left channel) and 1 for the last 128 (right channel). Setting `cfg_inv_ws` inverts it.
- R4: With `cfg_fmt` = 0 (I2S), the sample MSB sits in channel slot 1 and the following bits in slots 2..W. All other slots carry 0.
- R5: With `cfg_fmt` = 1 (left-justified), the MSB sits in slot 0 and the LSB in slot W-1. All other slots carry 0.
- R6: With `cfg_fmt` = 2 (right-justified), the LSB sits in slot 31 and the MSB in slot 32-W. All other slots carry 0.
- R7: The width code `cfg_width` is the sample width in binary. Only 8, 16, 18, 20 and 24 are legal. Any other code, and `cfg_fmt` = 3, give an all-zero data line while the clocks keep their normal framing.
- R8: A pair accepted on the transmit stream is taken from the FIFO at the end of the current frame and sent in the next frame, left word = `tx_left`. If the transmit FIFO is empty at a frame end while `cfg_tx_en` is high, zeros are sent and the sticky `tx_under` flag is set. Only `port_dis` clears it.
- R9: With loopback on, the pair captured in each frame, holding the low W bits of each word, is pushed to the receive FIFO at the frame's end. The first frame after start-up carries zeros. The receive stream holds its data until `rx_ready` is high.
- R10: If `cfg_rx_en` is high and the receive FIFO is full at a frame end, that frame is dropped and the sticky `rx_over` flag is set.
- R11: `sd_oe` equals the inverse of `cfg_pin_in`. Without loopback, the receiver samples `sd_in` in the middle of each bit period (master cycle 2 of the group of four).
- R12: With `clk_en` low the port is frozen: the clocks hold and no FIFO entry is taken. `port_dis` high clears the frame position, both FIFOs and the sticky flags.
- R13: FIFO flags, for a depth D: `tx_full` is high at D entries, `tx_req` is high at D/2 entries or fewer, `rx_full` is high at D entries and `rx_req` is high at D/2 entries or more. The level changes by exactly one per accepted push without a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Active-low reset |
| clk_en | input | 1 | Runs the frame counter when high |
| port_dis | input | 1 | Stops the port and clears the frame, FIFOs and flags |
| cfg_width | input | 5 | Sample width in bits, binary |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified |
| cfg_inv_bclk | input | 1 | Invert bit clock |
| cfg_inv_ws | input | 1 | Invert word select |
| cfg_pin_in | input | 1 | Turn the data pin into an input |
| cfg_loop | input | 1 | Receive the transmitted bits internally |
| cfg_tx_en | input | 1 | Enable the transmit FIFO |
| cfg_rx_en | input | 1 | Enable the receive FIFO |
| tx_valid | input | 1 | Transmit pair valid |
| tx_ready | output | 1 | Transmit FIFO can take a pair |
| tx_left | input | 24 | Left transmit sample |
| tx_right | input | 24 | Right transmit sample |
| rx_valid | output | 1 | Receive pair available |
| rx_ready | input | 1 | Consumer takes the receive pair |
| rx_left | output | 24 | Left received sample |
| rx_right | output | 24 | Right received sample |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data output enable |
| sd_in | input | 1 | Serial data in |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_req | output | 1 | Transmit FIFO at half or less |
| rx_full | output | 1 | Receive FIFO full |
| rx_req | output | 1 | Receive FIFO at half or more |
| tx_under | output | 1 | Sticky transmit underflow |
| rx_over | output | 1 | Sticky receive overflow |

## Verification
The hold checks on the bit clock, word select and data line assume that the format, width and polarity inputs do not change while the port runs. The bench therefore changes configuration only while `port_dis` is high. The sticky-flag and FIFO-level checks assume that the streams are handshaken only through valid/ready. Accordingly, the bench drives `sd_in` and the stream inputs only on falling edges, keeping them stable across each sampling edge. The sweep covers every format code and every legal width plus one illegal width, each with a different data pattern and polarity mix.

// File: rtl/i2sm_pkg.sv
package i2sm_pkg;
  localparam int MCLK_RATIO = 256;
  localparam int SLOT_BITS  = 32;
  localparam int CLK_DIV    = MCLK_RATIO / (2 * SLOT_BITS);
  localparam int DIV_LOG2   = $clog2(CLK_DIV);
  localparam int SLOT_LOG2  = $clog2(SLOT_BITS);

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } frame_fmt_e;

  function automatic logic width_legal(input logic [4:0] w);
    return (w == 5'd8) || (w == 5'd16) || (w == 5'd18) ||
           (w == 5'd20) || (w == 5'd24);
  endfunction
endpackage

// File: rtl/i2sm_fifo.sv
module i2sm_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [W-1:0]                 in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [W-1:0]                 out_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign in_ready  = (level != LW'(DEPTH));
  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R13
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/i2sm_frame_timer.sv
module i2sm_frame_timer #(
  parameter int DIV_LOG2  = 2,
  parameter int SLOT_LOG2 = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          run,
  output logic [DIV_LOG2+SLOT_LOG2:0]   cnt,
  output logic [SLOT_LOG2-1:0]          slot,
  output logic                          chan,
  output logic                          bclk_phase,
  output logic                          sample_pt,
  output logic                          frame_end
);
  localparam int CNT_W = DIV_LOG2 + SLOT_LOG2 + 1;
  localparam logic [DIV_LOG2-1:0] MID = DIV_LOG2'(1 << (DIV_LOG2 - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign slot       = cnt[DIV_LOG2 +: SLOT_LOG2];
  assign chan       = cnt[CNT_W-1];
  assign bclk_phase = cnt[DIV_LOG2-1];
  assign sample_pt  = (cnt[DIV_LOG2-1:0] == MID);
  assign frame_end  = &cnt;
endmodule

// File: rtl/i2sm_slot_map.sv
module i2sm_slot_map
  import i2sm_pkg::*;
(
  input  logic [4:0] slot,
  input  logic [1:0] fmt,
  input  logic [4:0] width,
  output logic       hit,
  output logic [4:0] idx
);
  logic [5:0] s6, w6;
  assign s6 = {1'b0, slot};
  assign w6 = {1'b0, width};

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (width_legal(width)) begin
      unique case (frame_fmt_e'(fmt))
        FMT_I2S: if (s6 >= 6'd1 && s6 <= w6) begin
          hit = 1'b1;
          idx = 5'(w6 - s6);
        end
        FMT_LEFT: if (s6 < w6) begin
          hit = 1'b1;
          idx = 5'(w6 - s6 - 6'd1);
        end
        FMT_RIGHT: if (s6 >= 6'd32 - w6) begin
          hit = 1'b1;
          idx = ~slot;
        end
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2sm_pkg::*;
#(
  parameter int MAX_W      = 24,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             port_dis,
  input  logic [4:0]       cfg_width,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_inv_bclk,
  input  logic             cfg_inv_ws,
  input  logic             cfg_pin_in,
  input  logic             cfg_loop,
  input  logic             cfg_tx_en,
  input  logic             cfg_rx_en,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [MAX_W-1:0] tx_left,
  input  logic [MAX_W-1:0] tx_right,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [MAX_W-1:0] rx_left,
  output logic [MAX_W-1:0] rx_right,
  output logic             bclk,
  output logic             ws,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in,
  output logic             tx_empty,
  output logic             tx_full,
  output logic             tx_req,
  output logic             rx_full,
  output logic             rx_req,
  output logic             tx_under,
  output logic             rx_over
);
  localparam int PAIR_W = 2 * MAX_W;
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int CNT_W  = DIV_LOG2 + SLOT_LOG2 + 1;

  logic                    run;
  logic [CNT_W-1:0]        cnt;
  logic [SLOT_LOG2-1:0]    slot;
  logic                    chan, bclk_phase, sample_pt, frame_end;
  logic                    hit;
  logic [4:0]              idx;
  logic [1:0][MAX_W-1:0]   tx_frame, rx_cap;
  logic                    sd_tx, rx_bit;
  logic                    txf_in_ready, txf_valid, tx_load;
  logic [PAIR_W-1:0]       txf_data, rxf_data;
  logic                    rx_push, rxf_in_ready;
  logic [LVL_W-1:0]        txf_level, rxf_level;
  logic [6:0]              cfg_word;

  assign run = clk_en && !port_dis;

  i2sm_frame_timer #(.DIV_LOG2(DIV_LOG2), .SLOT_LOG2(SLOT_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(port_dis), .run(run),
    .cnt(cnt), .slot(slot), .chan(chan), .bclk_phase(bclk_phase),
    .sample_pt(sample_pt), .frame_end(frame_end)
  );

  i2sm_slot_map u_map (
    .slot(slot), .fmt(cfg_fmt), .width(cfg_width), .hit(hit), .idx(idx)
  );

  assign sd_tx  = hit ? tx_frame[chan][idx] : 1'b0;
  assign sd_out = sd_tx;
  assign sd_oe  = !cfg_pin_in;
  assign rx_bit = cfg_loop ? sd_tx : sd_in;
  assign bclk   = run ? (bclk_phase ^ cfg_inv_bclk) : cfg_inv_bclk;
  assign ws     = chan ^ cfg_inv_ws;

  assign tx_ready = txf_in_ready && cfg_tx_en;
  assign tx_load  = run && frame_end && cfg_tx_en;
  assign rx_push  = run && frame_end && cfg_rx_en;

  i2sm_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(port_dis),
    .in_valid(tx_valid && cfg_tx_en), .in_ready(txf_in_ready),
    .in_data({tx_left, tx_right}),
    .out_valid(txf_valid), .out_ready(tx_load), .out_data(txf_data),
    .level(txf_level)
  );

  i2sm_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(port_dis),
    .in_valid(rx_push), .in_ready(rxf_in_ready),
    .in_data({rx_cap[0], rx_cap[1]}),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rxf_data),
    .level(rxf_level)
  );

  assign rx_left  = rxf_data[PAIR_W-1:MAX_W];
  assign rx_right = rxf_data[MAX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_frame <= '0;
      rx_cap   <= '0;
      tx_under <= 1'b0;
      rx_over  <= 1'b0;
    end else if (port_dis) begin
      tx_frame <= '0;
      rx_cap   <= '0;
      tx_under <= 1'b0;
      rx_over  <= 1'b0;
    end else if (run) begin
      if (sample_pt && hit) rx_cap[chan][idx] <= rx_bit;
      if (frame_end) begin
        tx_frame <= (tx_load && txf_valid) ?
                    {txf_data[MAX_W-1:0], txf_data[PAIR_W-1:MAX_W]} : '0;
        rx_cap   <= '0;
        if (tx_load && !txf_valid)    tx_under <= 1'b1;
        if (rx_push && !rxf_in_ready) rx_over  <= 1'b1;
      end
    end
  end

  assign tx_empty = (txf_level == '0);
  assign tx_full  = (txf_level == LVL_W'(FIFO_DEPTH));
  assign tx_req   = (txf_level <= LVL_W'(FIFO_DEPTH / 2));
  assign rx_full  = (rxf_level == LVL_W'(FIFO_DEPTH));
  assign rx_req   = (rxf_level >= LVL_W'(FIFO_DEPTH / 2));

  assign cfg_word = {cfg_fmt, cfg_width};

  // R2
  bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cfg_inv_bclk) && cnt[0]) |-> $stable(bclk));

  // R3
  ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cfg_inv_ws) && (cnt[CNT_W-2:0] != '0))
      |-> $stable(ws));

  // R4
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(cfg_word) && (cnt[DIV_LOG2-1:0] != '0))
      |-> $stable(sd_out));

  // R8
  under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_under) && !$past(port_dis)) |-> tx_under);

  // R10
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_over) && !$past(port_dis)) |-> rx_over);
endmodule

// File: tb/i2s_master_port_tb.sv
`timescale 1ns/1ps
module i2s_master_port_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clk_en, port_dis;
  logic [4:0] cfg_width;
  logic [1:0] cfg_fmt;
  logic cfg_inv_bclk, cfg_inv_ws, cfg_pin_in, cfg_loop, cfg_tx_en, cfg_rx_en;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [23:0] tx_left, tx_right, rx_left, rx_right;
  logic bclk, ws, sd_out, sd_oe, sd_in;
  logic tx_empty, tx_full, tx_req, rx_full, rx_req, tx_under, rx_over;

  i2s_master_port u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_dis(port_dis),
    .cfg_width(cfg_width), .cfg_fmt(cfg_fmt), .cfg_inv_bclk(cfg_inv_bclk),
    .cfg_inv_ws(cfg_inv_ws), .cfg_pin_in(cfg_pin_in), .cfg_loop(cfg_loop),
    .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .bclk(bclk), .ws(ws), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_req(tx_req),
    .rx_full(rx_full), .rx_req(rx_req), .tx_under(tx_under), .rx_over(rx_over)
  );

  int n_chk = 0;
  int n_bad = 0;
  int bc;

  // frame position per R2: advances on every running master clock
  always @(posedge clk) begin
    if (!rst_n || port_dis) bc <= 0;
    else if (clk_en)        bc <= bc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_w(input int w);
    return (w == 8) || (w == 16) || (w == 18) || (w == 20) || (w == 24);
  endfunction

  function automatic logic exp_bit(input int fmt, input int w, input int ch,
                                   input int s, input logic [23:0] l,
                                   input logic [23:0] r);
    logic [23:0] v;
    v = ch ? r : l;
    if (!legal_w(w)) return 1'b0;
    case (fmt)
      0: return (s >= 1 && s <= w) ? v[w - s] : 1'b0;
      1: return (s < w) ? v[w - 1 - s] : 1'b0;
      2: return (s >= 32 - w) ? v[31 - s] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_bc(input int t);
    @(negedge clk);
    while (bc != t) @(negedge clk);
  endtask

  task automatic restart();
    port_dis = 1'b1;
    @(negedge clk);
    port_dis = 1'b0;
  endtask

  task automatic push_pair(input logic [23:0] l, input logic [23:0] r);
    tx_left = l; tx_right = r; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic run_cfg(input int fmt, input int w, input bit ib, input bit iw,
                         input logic [23:0] l, input logic [23:0] r);
    int bit_err = 0, clk_err = 0, ws_err = 0;
    logic [23:0] mask, el, er;
    port_dis = 1'b1;
    @(negedge clk);
    cfg_fmt = 2'(fmt); cfg_width = 5'(w); cfg_inv_bclk = ib; cfg_inv_ws = iw;
    cfg_loop = 1'b1; cfg_pin_in = 1'b0; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
    @(negedge clk);
    port_dis = 1'b0;
    chk(tx_under == 1'b0, "R8", "under cleared by disable", tx_under, 0);
    push_pair(l, r);
    wait_bc(256);
    for (int k = 0; k < 256; k++) begin
      int ph = bc % 4;
      int s  = (bc % 128) / 4;
      int ch = (bc % 256) / 128;
      if (ph == 2 && sd_out !== exp_bit(fmt, w, ch, s, l, r)) bit_err++;
      if (bclk !== (((ph >= 2) ? 1'b1 : 1'b0) ^ ib)) clk_err++;
      if (ws !== (1'(ch) ^ iw)) ws_err++;
      @(negedge clk);
    end
    if (!legal_w(w) || fmt == 3)
      chk(bit_err == 0, "R7", "silent data line", bit_err, 0);
    else if (fmt == 0)
      chk(bit_err == 0, "R4", "i2s slot placement", bit_err, 0);
    else if (fmt == 1)
      chk(bit_err == 0, "R5", "left slot placement", bit_err, 0);
    else
      chk(bit_err == 0, "R6", "right slot placement", bit_err, 0);
    chk(clk_err == 0, "R2", "bit clock pattern", clk_err, 0);
    chk(ws_err == 0, "R3", "word select pattern", ws_err, 0);
    chk(sd_oe == 1'b1, "R11", "output enabled", sd_oe, 1);
    mask = (24'h1 << w) - 24'h1;
    el = (legal_w(w) && fmt != 3) ? (l & mask) : 24'h0;
    er = (legal_w(w) && fmt != 3) ? (r & mask) : 24'h0;
    chk(rx_valid == 1'b1 && rx_left == 24'h0 && rx_right == 24'h0, "R9",
        "first frame zero pair", {rx_valid, rx_left, rx_right}, {1'b1, 48'h0});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b1 && rx_left == el && rx_right == er, "R9",
        "loopback pair", {rx_left, rx_right}, {el, er});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(tx_under == 1'b1, "R8", "underflow on empty frame end", tx_under, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    automatic int widths[6] = '{8, 16, 18, 20, 24, 12};
    logic fb, fw;
    rst_n = 1'b0; clk_en = 1'b1; port_dis = 1'b0;
    cfg_width = 5'd16; cfg_fmt = 2'd0; cfg_inv_bclk = 1'b0; cfg_inv_ws = 1'b0;
    cfg_pin_in = 1'b0; cfg_loop = 1'b0; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
    tx_valid = 1'b0; tx_left = '0; tx_right = '0; rx_ready = 1'b0; sd_in = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_empty == 1'b1, "R1", "tx empty in reset", tx_empty, 1);
    chk(rx_valid == 1'b0, "R1", "no rx data in reset", rx_valid, 0);
    chk(tx_under == 1'b0 && rx_over == 1'b0, "R1", "sticky flags low",
        {tx_under, rx_over}, 0);
    chk(bclk == 1'b0, "R1", "bit clock idle", bclk, 0);
    port_dis = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;

    // sweep of formats and widths with loopback
    for (int f = 0; f < 4; f++) begin
      for (int wi = 0; wi < 6; wi++) begin
        automatic logic [23:0] l = 24'hA5C3F1 ^ 24'(f * 24'h1357 + wi * 24'h0F0F1);
        automatic logic [23:0] r = {l[11:0], ~l[23:12]} ^ 24'(wi * 24'h3C5);
        run_cfg(f, widths[wi], f[0], wi[0], l, r);
      end
    end

    // R12 freeze and R13 transmit flags
    port_dis = 1'b1; clk_en = 1'b0; cfg_inv_bclk = 1'b1;
    @(negedge clk);
    port_dis = 1'b0;
    @(negedge clk);
    push_pair(24'h111111, 24'h222222);
    chk(tx_empty == 1'b0 && tx_req == 1'b1, "R13", "one entry flags",
        {tx_empty, tx_req}, 2'b01);
    push_pair(24'h333333, 24'h444444);
    push_pair(24'h555555, 24'h666666);
    chk(tx_req == 1'b0 && tx_full == 1'b0, "R13", "three entry flags",
        {tx_req, tx_full}, 2'b00);
    push_pair(24'h777777, 24'h888888);
    chk(tx_full == 1'b1 && tx_ready == 1'b0, "R13", "full flag and ready",
        {tx_full, tx_ready}, 2'b10);
    fb = bclk; fw = ws;
    repeat (300) @(negedge clk);
    chk(bclk == 1'b1 && bclk == fb && ws == fw, "R12", "clocks held while frozen",
        {bclk, ws}, {1'b1, fw});
    chk(tx_full == 1'b1, "R12", "no pop while frozen", tx_full, 1);
    restart();
    chk(tx_empty == 1'b1, "R12", "disable flushes tx fifo", tx_empty, 1);
    clk_en = 1'b1; cfg_inv_bclk = 1'b0;

    // R10 receive overflow and R13 receive flags
    port_dis = 1'b1;
    @(negedge clk);
    cfg_tx_en = 1'b0; cfg_loop = 1'b1; rx_ready = 1'b0;
    @(negedge clk);
    port_dis = 1'b0;
    wait_bc(2 * 256 + 1);
    chk(rx_req == 1'b1 && rx_full == 1'b0, "R13", "rx half level",
        {rx_req, rx_full}, 2'b10);
    wait_bc(4 * 256 + 1);
    chk(rx_full == 1'b1 && rx_over == 1'b0, "R10", "full but not overflowed",
        {rx_full, rx_over}, 2'b10);
    wait_bc(5 * 256 + 1);
    chk(rx_over == 1'b1, "R10", "overflow on full frame end", rx_over, 1);
    wait_bc(5 * 256 + 60);
    chk(rx_over == 1'b1 && tx_under == 1'b0, "R10", "overflow sticky, no tx underflow",
        {rx_over, tx_under}, 2'b10);

    // R11 pin as input, no loopback
    port_dis = 1'b1;
    @(negedge clk);
    cfg_tx_en = 1'b1; cfg_loop = 1'b0; cfg_pin_in = 1'b1;
    cfg_fmt = 2'd1; cfg_width = 5'd16;
    @(negedge clk);
    port_dis = 1'b0;
    chk(sd_oe == 1'b0, "R11", "pin turned to input", sd_oe, 0);
    for (int k = 0; k < 256; k++) begin
      sd_in = exp_bit(1, 16, (bc % 256) / 128, (bc % 128) / 4, 24'h00C3A5, 24'h005A7E);
      @(negedge clk);
    end
    sd_in = 1'b0;
    chk(rx_valid == 1'b1 && rx_left == 24'h00C3A5 && rx_right == 24'h005A7E, "R11",
        "pair received from pin", {rx_left, rx_right}, {24'h00C3A5, 24'h005A7E});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule